// File: doc/BRIEF.md
# Interrupt Control and State Register

This block is the software-visible control and status word of a small interrupt controller. Through one 32-bit location on a simple register bus, software can pend the non-maskable interrupt, and can set or clear the pending state of two system exceptions: a deferred-service exception and a timer tick exception. The same word reports whether any external interrupt is waiting, the exception number of the most urgent pending source, and the number of the exception currently being serviced.

Hardware sources (an NMI request, a tick request and one request line per external interrupt) also pend their sources. A pended bit stays set until software clears it, or until the surrounding controller accepts that exception with an accept strobe and its exception number. Exception numbers are fixed: NMI is 2, the deferred-service exception is 14, the tick is 15 and external interrupt i is 16 + i. The pending state of every source is driven out to the rest of the controller.

Top module: `irq_ctl_stat`

## Requirements
- R1: After reset all pending outputs are 0 and the word reads back 0 apart from the active field, which shows the active-vector input.
- R2: A write with bit 31 at 1 pends the NMI; bit 31 at 0 leaves the NMI state unchanged. Bit 31 reads the NMI pending state.
- R3: A write with bit 28 at 1 pends the deferred-service exception and bit 27 at 1 clears it; 0 in either bit has no effect. Bit 28 reads its pending state.
- R4: A write with bit 26 at 1 pends the tick exception and bit 25 at 1 clears it; 0 in either bit has no effect. Bit 26 reads its pending state; the tick request input also pends it.
- R5: When a set (written or from a request input) and a clear or accept for the same source happen in one cycle, the source ends up not pending.
- R6: Bit 22 reads 1 exactly when at least one external interrupt is pending; NMI, deferred-service and tick do not count.
- R7: Bits 17:12 give the number of the most urgent pending source in the order NMI (2), deferred-service (14), tick (15), then external interrupts by ascending number (16 + i); 0 when nothing is pending.
- R8: Bits 8:0 read the active-vector input; writes to these bits have no effect.
- R9: Bits 30:29, 27, 25, 24, 23, 21:18 and 11:9 always read 0.
- R10: A pulse on an external request input pends that interrupt and it stays pending for any number of cycles until accepted.
- R11: An accept strobe with an exception number clears only the source with that number; a number that matches no pending source changes nothing.
- R12: Reads at any other address return 0 and writes there change no state.
- R13: The pending outputs equal the pending state that the word reads back (bit 31, bit 28, bit 26, one output per external interrupt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| nmi_req_i | input | 1 | Hardware request that pends the NMI |
| tick_req_i | input | 1 | Hardware request that pends the tick exception |
| irq_req_i | input | NUM_IRQ | Per external interrupt request |
| ack_valid_i | input | 1 | Accept strobe from the exception sequencer |
| ack_vec_i | input | 6 | Exception number being accepted |
| act_vec_i | input | 9 | Number of the exception now active |
| nmi_pend_o | output | 1 | NMI pending |
| dsv_pend_o | output | 1 | Deferred-service exception pending |
| tick_pend_o | output | 1 | Tick exception pending |
| irq_pend_o | output | NUM_IRQ | External interrupts pending |

## Verification
The priority field is driven with single sources of each class, then with a stack built up source by source (two external interrupts, then tick, deferred-service and NMI) and torn down again by clears and accepts, which tells a wrong order between classes apart from a wrong order among external interrupts. Set and clear patterns are written with each bit alone, with zeros, with set and clear together and with a hardware set colliding with a software clear, separating no-effect writes from precedence mistakes. An all-ones write and writes at a foreign address show that reserved, write-only and active bits cannot be disturbed, and mismatched accept numbers show that accepts are exact.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int VEC_W    = 6;
    localparam int ACT_W    = 9;
    localparam int NMI_VEC  = 2;
    localparam int DSV_VEC  = 14;
    localparam int TICK_VEC = 15;
    localparam int EXT_BASE = 16;
    localparam int MAX_IRQ  = (1 << VEC_W) - EXT_BASE;

    localparam int B_NMI_SET  = 31;
    localparam int B_DSV_SET  = 28;
    localparam int B_DSV_CLR  = 27;
    localparam int B_TICK_SET = 26;
    localparam int B_TICK_CLR = 25;
    localparam int B_EXT_ANY  = 22;
    localparam int B_VEC_LO   = 12;

    localparam logic [31:0] RSVD_MASK = 32'h6BBC_0E00;

    typedef struct packed {
        logic nmi;
        logic dsv;
        logic tick;
    } sys_pend_t;

    typedef struct packed {
        logic set_nmi;
        logic set_dsv;
        logic clr_dsv;
        logic set_tick;
        logic clr_tick;
    } sw_cmd_t;

endpackage

// File: rtl/irq_sys_pend.sv
module irq_sys_pend
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sw_cmd_t          cmd,
    input  logic             nmi_req,
    input  logic             tick_req,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vec,
    output sys_pend_t        pend
);

    sys_pend_t st_d, st_q;
    logic      ack_nmi, ack_dsv, ack_tick;

    always_comb begin
        ack_nmi  = ack_valid && (ack_vec == VEC_W'(NMI_VEC));
        ack_dsv  = ack_valid && (ack_vec == VEC_W'(DSV_VEC));
        ack_tick = ack_valid && (ack_vec == VEC_W'(TICK_VEC));

        st_d = st_q;
        // set first, then clear/accept so that removal wins
        if (cmd.set_nmi || nmi_req)     st_d.nmi  = 1'b1;
        if (ack_nmi)                    st_d.nmi  = 1'b0;
        if (cmd.set_dsv)                st_d.dsv  = 1'b1;
        if (cmd.clr_dsv || ack_dsv)     st_d.dsv  = 1'b0;
        if (cmd.set_tick || tick_req)   st_d.tick = 1'b1;
        if (cmd.clr_tick || ack_tick)   st_d.tick = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q;

endmodule

// File: rtl/irq_ext_pend.sv
module irq_ext_pend
    import irq_ctl_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               ack_valid,
    input  logic [VEC_W-1:0]   ack_vec,
    output logic [NUM_IRQ-1:0] pend
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] bits;
    } ext_st_t;

    ext_st_t            st_d, st_q;
    logic [NUM_IRQ-1:0] ack_hit;

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_hit
        localparam int VNUM = EXT_BASE + gi;
        assign ack_hit[gi] = ack_valid && (ack_vec == VEC_W'(VNUM));
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits | irq_req) & ~ack_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.bits;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_ctl_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  sys_pend_t          sys,
    input  logic [NUM_IRQ-1:0] ext,
    output logic [VEC_W-1:0]   top_vec,
    output logic               ext_any
);

    logic [VEC_W-1:0] ext_vec;

    // lowest-numbered external interrupt wins among externals
    always_comb begin
        ext_vec = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (ext[i]) ext_vec = VEC_W'(EXT_BASE + i);
        end
    end

    always_comb begin
        ext_any = |ext;
        if (sys.nmi)       top_vec = VEC_W'(NMI_VEC);
        else if (sys.dsv)  top_vec = VEC_W'(DSV_VEC);
        else if (sys.tick) top_vec = VEC_W'(TICK_VEC);
        else               top_vec = ext_vec;
    end

endmodule

// File: rtl/irq_ctl_stat.sv
module irq_ctl_stat
    import irq_ctl_pkg::*;
#(
    parameter int          NUM_IRQ  = 8,
    parameter int          ADDR_W   = 12,
    parameter int unsigned REG_ADDR = 32'h0000_0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               nmi_req_i,
    input  logic               tick_req_i,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic               ack_valid_i,
    input  logic [5:0]         ack_vec_i,
    input  logic [8:0]         act_vec_i,
    output logic               nmi_pend_o,
    output logic               dsv_pend_o,
    output logic               tick_pend_o,
    output logic [NUM_IRQ-1:0] irq_pend_o
);

    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

    if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ) begin : g_bad_count
        initial $error("NUM_IRQ out of range for a 6-bit exception number");
    end

    logic               sel, wr;
    sw_cmd_t            cmd;
    sys_pend_t          sys_pend;
    logic [NUM_IRQ-1:0] ext_pend;
    logic [VEC_W-1:0]   top_vec;
    logic               ext_any;
    logic               unused_wdata;

    always_comb begin
        sel          = (bus_addr == SEL_ADDR);
        wr           = sel && bus_we;
        cmd.set_nmi  = wr && bus_wdata[B_NMI_SET];
        cmd.set_dsv  = wr && bus_wdata[B_DSV_SET];
        cmd.clr_dsv  = wr && bus_wdata[B_DSV_CLR];
        cmd.set_tick = wr && bus_wdata[B_TICK_SET];
        cmd.clr_tick = wr && bus_wdata[B_TICK_CLR];
    end

    assign unused_wdata = ^bus_wdata;

    irq_sys_pend u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .nmi_req   (nmi_req_i),
        .tick_req  (tick_req_i),
        .ack_valid (ack_valid_i),
        .ack_vec   (ack_vec_i),
        .pend      (sys_pend)
    );

    irq_ext_pend #(.NUM_IRQ(NUM_IRQ)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req_i),
        .ack_valid (ack_valid_i),
        .ack_vec   (ack_vec_i),
        .pend      (ext_pend)
    );

    irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .sys     (sys_pend),
        .ext     (ext_pend),
        .top_vec (top_vec),
        .ext_any (ext_any)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel) begin
            bus_rdata[B_NMI_SET]                 = sys_pend.nmi;
            bus_rdata[B_DSV_SET]                 = sys_pend.dsv;
            bus_rdata[B_TICK_SET]                = sys_pend.tick;
            bus_rdata[B_EXT_ANY]                 = ext_any;
            bus_rdata[B_VEC_LO +: VEC_W]         = top_vec;
            bus_rdata[ACT_W-1:0]                 = act_vec_i;
        end
    end

    assign nmi_pend_o  = sys_pend.nmi;
    assign dsv_pend_o  = sys_pend.dsv;
    assign tick_pend_o = sys_pend.tick;
    assign irq_pend_o  = ext_pend;

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_ctl_pkg::*;
#(
    parameter int          NUM_IRQ  = 8,
    parameter int          ADDR_W   = 12,
    parameter int unsigned REG_ADDR = 32'h0000_0010
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic               ack_valid_i,
    input logic [5:0]         ack_vec_i,
    input logic [8:0]         act_vec_i,
    input logic               nmi_pend_o,
    input logic               dsv_pend_o,
    input logic               tick_pend_o,
    input logic [NUM_IRQ-1:0] irq_pend_o
);

    logic sel, wr, nothing;
    assign sel     = (bus_addr == ADDR_W'(REG_ADDR));
    assign wr      = sel && bus_we;
    assign nothing = !nmi_pend_o && !dsv_pend_o && !tick_pend_o && (irq_pend_o == '0);

    AST_NMI_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_wdata[31] && !(ack_valid_i && ack_vec_i == 6'd2) |=> nmi_pend_o); // R2
    AST_DSV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_wdata[28] && !bus_wdata[27] && !(ack_valid_i && ack_vec_i == 6'd14) |=> dsv_pend_o); // R3
    AST_DSV_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_wdata[27] |=> !dsv_pend_o); // R5
    AST_TICK_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_wdata[25] |=> !tick_pend_o); // R5
    AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> bus_rdata[22] == (|irq_pend_o)); // R6
    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel && nothing |-> bus_rdata[17:12] == 6'd0); // R7
    AST_VEC_NMI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        sel && nmi_pend_o |-> bus_rdata[17:12] == 6'd2); // R7
    AST_ACT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> bus_rdata[8:0] == act_vec_i); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSVD_MASK) == 32'd0); // R9
    AST_NMI_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_i && ack_vec_i == 6'd2 |=> !nmi_pend_o); // R11
    AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> bus_rdata == 32'd0); // R12
    AST_PEND_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> bus_rdata[31] == nmi_pend_o && bus_rdata[28] == dsv_pend_o
                && bus_rdata[26] == tick_pend_o); // R13

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_hold
        localparam int VNUM = EXT_BASE + gi;
        AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pend_o[gi] && !(ack_valid_i && ack_vec_i == 6'(VNUM)) |=> irq_pend_o[gi]); // R10
    end

endmodule

bind irq_ctl_stat irq_ctl_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ack_valid_i (ack_valid_i),
    .ack_vec_i   (ack_vec_i),
    .act_vec_i   (act_vec_i),
    .nmi_pend_o  (nmi_pend_o),
    .dsv_pend_o  (dsv_pend_o),
    .tick_pend_o (tick_pend_o),
    .irq_pend_o  (irq_pend_o)
);

// File: tb/sim_irq_ctl_stat.sv
module sim_irq_ctl_stat;

    localparam int          NUM_IRQ  = 8;
    localparam int          ADDR_W   = 12;
    localparam int unsigned REG_ADDR = 32'h10;
    localparam logic [ADDR_W-1:0] RA = ADDR_W'(REG_ADDR);
    localparam logic [ADDR_W-1:0] OTHER = ADDR_W'(REG_ADDR + 4);
    localparam logic [31:0] RSVD = 32'h6BBC_0E00;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = RA;
    logic               bus_we = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               nmi_req_i = 1'b0;
    logic               tick_req_i = 1'b0;
    logic [NUM_IRQ-1:0] irq_req_i = '0;
    logic               ack_valid_i = 1'b0;
    logic [5:0]         ack_vec_i = '0;
    logic [8:0]         act_vec_i = '0;
    logic               nmi_pend_o, dsv_pend_o, tick_pend_o;
    logic [NUM_IRQ-1:0] irq_pend_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_ctl_stat #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_req_i(nmi_req_i),
        .tick_req_i(tick_req_i), .irq_req_i(irq_req_i), .ack_valid_i(ack_valid_i),
        .ack_vec_i(ack_vec_i), .act_vec_i(act_vec_i), .nmi_pend_o(nmi_pend_o),
        .dsv_pend_o(dsv_pend_o), .tick_pend_o(tick_pend_o), .irq_pend_o(irq_pend_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(output logic [31:0] d);
        bus_addr = RA;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_at(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; bus_addr = RA;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_at(RA, d);
    endtask

    task automatic ack(input logic [5:0] v);
        @(negedge clk);
        ack_valid_i = 1'b1; ack_vec_i = v;
        @(negedge clk);
        ack_valid_i = 1'b0; ack_vec_i = '0;
    endtask

    task automatic pulse_irq(input logic [NUM_IRQ-1:0] m);
        @(negedge clk);
        irq_req_i = m;
        @(negedge clk);
        irq_req_i = '0;
    endtask

    function automatic logic [31:0] outs();
        return {dsv_pend_o, tick_pend_o, nmi_pend_o, 21'd0, irq_pend_o};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(d);
        chk("R1 reset word", d, 32'h0);
        chk("R1 reset outputs", outs(), 32'h0);
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        wr(32'h0);
        rd(d);
        chk("R2 zero write no effect", d, 32'h0);
        wr(32'h8000_0000);
        rd(d);
        chk("R2 nmi pended, R7 vec 2", d, 32'h8000_2000);
        chk("R13 nmi output", {31'd0, nmi_pend_o}, 32'd1);
        ack(6'd5);
        rd(d);
        chk("R11 mismatched accept", d, 32'h8000_2000);
        ack(6'd2);
        rd(d);
        chk("R11 nmi accepted", d, 32'h0);
    endtask

    task automatic t_dsv();
        logic [31:0] d;
        wr(32'h1000_0000);
        rd(d);
        chk("R3 dsv set", d, 32'h1000_E000);
        wr(32'h0);
        rd(d);
        chk("R3 zero keeps dsv", d, 32'h1000_E000);
        chk("R13 dsv output", {31'd0, dsv_pend_o}, 32'd1);
        wr(32'h0800_0000);
        rd(d);
        chk("R3 dsv cleared", d, 32'h0);
    endtask

    task automatic t_tick();
        logic [31:0] d;
        wr(32'h0400_0000);
        rd(d);
        chk("R4 tick set", d, 32'h0400_F000);
        wr(32'h0200_0000);
        rd(d);
        chk("R4 tick cleared", d, 32'h0);
        @(negedge clk); tick_req_i = 1'b1;
        @(negedge clk); tick_req_i = 1'b0;
        rd(d);
        chk("R4 tick from request", d, 32'h0400_F000);
        wr(32'h0200_0000);
    endtask

    task automatic t_clear_wins();
        logic [31:0] d;
        wr(32'h1800_0000);
        rd(d);
        chk("R5 dsv set+clear from idle", d, 32'h0);
        wr(32'h1000_0000);
        wr(32'h1800_0000);
        rd(d);
        chk("R5 dsv set+clear while pending", d, 32'h0);
        @(negedge clk);
        tick_req_i = 1'b1; bus_we = 1'b1; bus_wdata = 32'h0200_0000;
        @(negedge clk);
        tick_req_i = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rd(d);
        chk("R5 tick request vs clear", d, 32'h0);
    endtask

    task automatic t_ext();
        logic [31:0] d;
        pulse_irq(8'h08);
        rd(d);
        chk("R6 ext flag and R7 vec 19", d, 32'h0041_3000);
        repeat (20) @(negedge clk);
        rd(d);
        chk("R10 ext held", d, 32'h0041_3000);
        chk("R13 ext outputs", outs(), 32'h0000_0008);
        ack(6'd20);
        rd(d);
        chk("R11 other ext number", d, 32'h0041_3000);
        ack(6'd19);
        rd(d);
        chk("R11 ext accepted", d, 32'h0);
        wr(32'h8000_0000);
        wr(32'h1400_0000);
        rd(d);
        chk("R6 system sources not in flag", {31'd0, d[22]}, 32'd0);
        ack(6'd2); ack(6'd14); ack(6'd15);
        rd(d);
        chk("R11 system accepts", d, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        pulse_irq(8'h22);
        rd(d);
        chk("R7 lowest ext first", d, 32'h0041_1000);
        wr(32'h0400_0000);
        rd(d);
        chk("R7 tick over ext", d, 32'h0440_F000);
        wr(32'h1000_0000);
        rd(d);
        chk("R7 dsv over tick", d, 32'h1440_E000);
        wr(32'h8000_0000);
        rd(d);
        chk("R7 nmi over all", d, 32'h9440_2000);
        ack(6'd2);
        wr(32'h0800_0000);
        rd(d);
        chk("R7 back to tick", d, 32'h0440_F000);
        wr(32'h0200_0000);
        ack(6'd17);
        rd(d);
        chk("R7 next ext", d, 32'h0041_5000);
        ack(6'd21);
        rd(d);
        chk("R7 empty reads 0", d, 32'h0);
    endtask

    task automatic t_act_rsvd();
        logic [31:0] d;
        act_vec_i = 9'h1A5;
        rd(d);
        chk("R8 active follows input", d, 32'h0000_01A5);
        wr(32'h0000_01FF);
        rd(d);
        chk("R8 active not writable", d, 32'h0000_01A5);
        chk("R8 no pend from write", outs(), 32'h0);
        act_vec_i = '0;
        wr(32'hFFFF_FFFF);
        rd(d);
        chk("R9 reserved zero", d & RSVD, 32'h0);
        chk("R9 all-ones result", d, 32'h8000_2000);
        ack(6'd2);
    endtask

    task automatic t_addr();
        logic [31:0] d;
        wr_at(OTHER, 32'h9400_0000);
        rd(d);
        chk("R12 foreign write ignored", d, 32'h0);
        wr(32'h8000_0000);
        bus_addr = OTHER;
        #1;
        chk("R12 foreign read zero", bus_rdata, 32'h0);
        bus_addr = RA;
        ack(6'd2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nmi();
        t_dsv();
        t_tick();
        t_clear_wins();
        t_ext();
        t_prio();
        t_act_rsvd();
        t_addr();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule